// File: doc/BRIEF.md
# Event Flag Combiner

The block latches up to 128 event inputs into sticky flag bits. The flags are kept as four groups of 32, so event number n lives in group n/32 at bit n mod 32. Software reaches the block through a plain 32-bit register port. Through it, software can force flags on, knock them off, and program two independent masks per group. One mask feeds a per-group combined interrupt line. The other feeds a single exception line shared by all groups.

A typical handler works like this. It reads the masked-flag word of the group whose combined line is high and picks the lowest set bit. It clears that bit with a write-one clear and repeats until the line drops. Because the combined line is a level derived from the latched flags, no event is lost between the read and the clear.

The register port has no back-pressure. A write is taken on every rising clock edge where `bus_wr` is high, and its effect is visible from the next cycle. Read data is a combinational function of `bus_addr` and the current register state.

Top module: `evt_combiner`

## Requirements
- R1: After reset every flag is 0, every event-mask and exception-mask bit is 1, and `comb_irq` and `exc_irq` are low.
- R2: A 0-to-1 transition on `evt_in[n]` sets flag bit n mod 32 of group n/32 at the following clock edge. An input that stays high does not set the flag again after it has been cleared. The flag words are read at byte offset 0x00 + 4*g.
- R3: A write to the set word of group g (offset 0x20 + 4*g) turns on every flag bit written as 1. Bits written as 0 are unchanged.
- R4: A write to the clear word of group g (offset 0x40 + 4*g) turns off every flag bit written as 1. Bits written as 0 are unchanged. When a rising input edge and a clear of the same bit meet at one clock edge, the flag ends set.
- R5: The event mask of group g is at offset 0x80 + 4*g and is read/write. A mask bit of 1 blocks the event. The masked-flag word at 0xA0 + 4*g reads flag AND NOT event-mask. Writes to the masked-flag and flag words are ignored.
- R6: `comb_irq[g]` is the OR of group g's masked-flag word. It stays high for as long as any unmasked flag of that group is set.
- R7: The exception mask of group g is at 0xC0 + 4*g and is independent of the event mask. The masked-exception word at 0xE0 + 4*g reads flag AND NOT exception-mask. `exc_irq` is the OR of all masked-exception words.
- R8: A write of value n to the event-assert word at 0x1C0 sets flag bit n mod 32 of group n/32. A value of 128 or more changes nothing.
- R9: Words 4..7 of each array, the unused arrays, misaligned addresses, and the write-only set, clear and assert words all read 0. Writes to reserved words have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 128 | Event inputs; a rising edge latches a flag |
| bus_wr | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | 9 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| comb_irq | output | 4 | Per-group combined interrupt level |
| exc_irq | output | 1 | Exception level across all groups |

## Verification
A corrupted flag or mask bit shows up in the cycle after it goes wrong. It appears in the flag and masked words on `bus_rdata`, and it moves `comb_irq` or `exc_irq` whenever the bit is unmasked. The bench therefore reads back the affected word, and checks both output lines, one cycle after each write or input edge. A wrongly decoded address shows as data appearing at a reserved or wrong group word. A lost edge-versus-clear priority shows as a cleared flag where the flag should have been held.

// File: rtl/evc_pkg.sv
`timescale 1ns/1ps
package evc_pkg;
  localparam int DW   = 32;
  localparam int AW   = 9;
  localparam int MAXG = 8;

  typedef enum logic [3:0] {
    BK_FLAG   = 4'h0,
    BK_SET    = 4'h1,
    BK_CLR    = 4'h2,
    BK_EMASK  = 4'h4,
    BK_MFLAG  = 4'h5,
    BK_XMASK  = 4'h6,
    BK_MXFLAG = 4'h7,
    BK_ASSERT = 4'hE
  } bank_e;
endpackage

// File: rtl/evc_group.sv
`timescale 1ns/1ps
module evc_group #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_in,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hit,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic         emask_we,
  input  logic         xmask_we,
  output logic [W-1:0] flag,
  output logic [W-1:0] emask,
  output logic [W-1:0] xmask,
  output logic [W-1:0] mflag,
  output logic [W-1:0] mxflag,
  output logic         comb,
  output logic         xany
);
  logic [W-1:0] evt_q, edge_v, set_v, clr_v;

  always_comb begin
    edge_v = evt_in & ~evt_q;
    set_v  = (set_we ? wdata : '0) | hit | edge_v;
    clr_v  = clr_we ? wdata : '0;
  end

  // set sources are applied after the clear, so an edge beats a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      flag  <= '0;
      emask <= '1;
      xmask <= '1;
    end else begin
      evt_q <= evt_in;
      flag  <= (flag & ~clr_v) | set_v;
      if (emask_we) emask <= wdata;
      if (xmask_we) xmask <= wdata;
    end
  end

  assign mflag  = flag & ~emask;
  assign mxflag = flag & ~xmask;
  assign comb   = |mflag;
  assign xany   = |mxflag;

  for (genvar b = 0; b < W; b++) begin : g_bitchk
    assert_flag_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[b]) |-> $past(evt_in[b] || (set_we && wdata[b]) || hit[b]));
    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && wdata[b] && !(evt_in[b] && !evt_q[b]) && !hit[b]) |=> !flag[b]);
  end

  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !emask_we |=> $stable(emask));
  assert_xmask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !xmask_we |=> $stable(xmask));
  assert_comb_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(comb) |-> $past(clr_we || emask_we));
endmodule

// File: rtl/evc_decode.sv
`timescale 1ns/1ps
module evc_decode
  import evc_pkg::*;
#(
  parameter int NG = 4
) (
  input  logic                bus_wr,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic                aligned,
  output bank_e               bank,
  output logic [2:0]          word,
  output logic [NG-1:0]       set_we,
  output logic [NG-1:0]       clr_we,
  output logic [NG-1:0]       emask_we,
  output logic [NG-1:0]       xmask_we,
  output logic [NG*DW-1:0]    hit
);
  localparam int NEVT = NG * DW;
  localparam int IW   = $clog2(NEVT);

  logic wr_ok, asrt_ok;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign bank    = bank_e'(bus_addr[8:5]);
  assign word    = bus_addr[4:2];
  assign wr_ok   = bus_wr && aligned;

  for (genvar g = 0; g < NG; g++) begin : g_strobe
    assign set_we[g]   = wr_ok && (bank == BK_SET)   && (word == 3'(g));
    assign clr_we[g]   = wr_ok && (bank == BK_CLR)   && (word == 3'(g));
    assign emask_we[g] = wr_ok && (bank == BK_EMASK) && (word == 3'(g));
    assign xmask_we[g] = wr_ok && (bank == BK_XMASK) && (word == 3'(g));
  end

  assign asrt_ok = wr_ok && (bank == BK_ASSERT) && (word == 3'd0)
                   && (bus_wdata < DW'(NEVT));
  assign hit = asrt_ok ? ({{(NEVT-1){1'b0}}, 1'b1} << bus_wdata[IW-1:0]) : '0;
endmodule

// File: rtl/evt_combiner.sv
`timescale 1ns/1ps
module evt_combiner
  import evc_pkg::*;
#(
  parameter int N_GROUPS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_GROUPS*DW-1:0] evt_in,
  input  logic                   bus_wr,
  input  logic [AW-1:0]          bus_addr,
  input  logic [DW-1:0]          bus_wdata,
  output logic [DW-1:0]          bus_rdata,
  output logic [N_GROUPS-1:0]    comb_irq,
  output logic                   exc_irq
);
  localparam int NEVT = N_GROUPS * DW;

  logic          aligned;
  bank_e         bank;
  logic [2:0]    word;
  logic [N_GROUPS-1:0] set_we, clr_we, emask_we, xmask_we, xany;
  logic [NEVT-1:0]     hit;
  logic [DW-1:0] flag_w [N_GROUPS];
  logic [DW-1:0] emask_w [N_GROUPS];
  logic [DW-1:0] xmask_w [N_GROUPS];
  logic [DW-1:0] mflag_w [N_GROUPS];
  logic [DW-1:0] mxflag_w [N_GROUPS];

  evc_decode #(.NG(N_GROUPS)) u_dec (
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .aligned(aligned), .bank(bank), .word(word),
    .set_we(set_we), .clr_we(clr_we), .emask_we(emask_we),
    .xmask_we(xmask_we), .hit(hit)
  );

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    evc_group #(.W(DW)) u_grp (
      .clk(clk), .rst_n(rst_n),
      .evt_in(evt_in[g*DW +: DW]), .wdata(bus_wdata), .hit(hit[g*DW +: DW]),
      .set_we(set_we[g]), .clr_we(clr_we[g]),
      .emask_we(emask_we[g]), .xmask_we(xmask_we[g]),
      .flag(flag_w[g]), .emask(emask_w[g]), .xmask(xmask_w[g]),
      .mflag(mflag_w[g]), .mxflag(mxflag_w[g]),
      .comb(comb_irq[g]), .xany(xany[g])
    );
  end

  assign exc_irq = |xany;

  always_comb begin
    bus_rdata = '0;
    for (int g = 0; g < N_GROUPS; g++) begin
      if (aligned && word == 3'(g)) begin
        case (bank)
          BK_FLAG:   bus_rdata = flag_w[g];
          BK_EMASK:  bus_rdata = emask_w[g];
          BK_MFLAG:  bus_rdata = mflag_w[g];
          BK_XMASK:  bus_rdata = xmask_w[g];
          BK_MXFLAG: bus_rdata = mxflag_w[g];
          default:   bus_rdata = '0;
        endcase
      end
    end
  end

  assert_exc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(exc_irq) |-> $past((|clr_we) || (|xmask_we)));
  assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_we, clr_we, emask_we, xmask_we}));
endmodule

// File: tb/sim_evt_combiner.sv
`timescale 1ns/1ps
module sim_evt_combiner;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] evt_in = '0;
  logic         bus_wr = 1'b0;
  logic [8:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [3:0]   comb_irq;
  logic         exc_irq;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  evt_combiner u0 (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .comb_irq(comb_irq), .exc_irq(exc_irq)
  );

  typedef struct packed {
    logic        wen;
    logic [8:0]  waddr;
    logic [31:0] wdata;
    logic [8:0]  raddr;
    logic [31:0] rexp;
    logic [3:0]  cexp;
    logic        xexp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 9'h000, 32'h0,        9'h080, 32'hFFFF_FFFF, 4'b0000, 1'b0, 8'd1}, // R1
    '{1'b0, 9'h000, 32'h0,        9'h0C4, 32'hFFFF_FFFF, 4'b0000, 1'b0, 8'd1}, // R1
    '{1'b1, 9'h020, 32'h11,       9'h000, 32'h11,        4'b0000, 1'b0, 8'd3}, // R3
    '{1'b0, 9'h000, 32'h0,        9'h0A0, 32'h0,         4'b0000, 1'b0, 8'd5}, // R5
    '{1'b1, 9'h080, 32'hFFFF_FFEF,9'h0A0, 32'h10,        4'b0001, 1'b0, 8'd6}, // R6
    '{1'b1, 9'h000, 32'h0,        9'h000, 32'h11,        4'b0001, 1'b0, 8'd5}, // R5
    '{1'b1, 9'h040, 32'h10,       9'h000, 32'h01,        4'b0000, 1'b0, 8'd4}, // R4
    '{1'b1, 9'h1C0, 32'd70,       9'h008, 32'h40,        4'b0000, 1'b0, 8'd8}, // R8
    '{1'b1, 9'h0C8, 32'hFFFF_FFBF,9'h0E8, 32'h40,        4'b0000, 1'b1, 8'd7}, // R7
    '{1'b0, 9'h000, 32'h0,        9'h0A8, 32'h0,         4'b0000, 1'b1, 8'd7}, // R7
    '{1'b1, 9'h1C0, 32'd200,      9'h008, 32'h40,        4'b0000, 1'b1, 8'd8}, // R8
    '{1'b1, 9'h060, 32'hFFFF_FFFF,9'h060, 32'h0,         4'b0000, 1'b1, 8'd9}, // R9
    '{1'b0, 9'h000, 32'h0,        9'h010, 32'h0,         4'b0000, 1'b1, 8'd9}, // R9
    '{1'b0, 9'h000, 32'h0,        9'h020, 32'h0,         4'b0000, 1'b1, 8'd9}, // R9
    '{1'b1, 9'h048, 32'h40,       9'h0E8, 32'h0,         4'b0000, 1'b0, 8'd7}, // R7
    '{1'b1, 9'h1C0, 32'd127,      9'h00C, 32'h8000_0000, 4'b0000, 1'b0, 8'd8}, // R8
    '{1'b1, 9'h08C, 32'h7FFF_FFFF,9'h0AC, 32'h8000_0000, 4'b1000, 1'b0, 8'd6}  // R6
  };

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [8:0] a,
                     input logic [31:0] rexp, input logic [3:0] cexp, input logic xexp);
    bus_addr = a;
    #1;
    checks++;
    if (bus_rdata !== rexp || comb_irq !== cexp || exc_irq !== xexp) begin
      errors++;
      $display("FAIL %s addr=%h rdata=%h exp=%h comb=%b exp=%b exc=%b exp=%b",
               tag, a, bus_rdata, rexp, comb_irq, cexp, exc_irq, xexp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 9'h000, 32'h0, 4'b0000, 1'b0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wen) wr(VEC[i].waddr, VEC[i].wdata);
      chk($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].raddr,
          VEC[i].rexp, VEC[i].cexp, VEC[i].xexp);
    end

    // R2: rising edge on event 33 latches group 1 bit 1
    @(negedge clk);
    evt_in[33] = 1'b1;
    @(negedge clk);
    chk("R2 edge", 9'h004, 32'h2, 4'b1000, 1'b0);
    wr(9'h044, 32'h2);
    repeat (3) @(negedge clk);
    chk("R2 held level", 9'h004, 32'h0, 4'b1000, 1'b0);
    evt_in[33] = 1'b0;

    // R4: edge and clear of the same bit at one clock edge -> flag stays
    wr(9'h024, 32'h20);
    chk("R3 set g1", 9'h004, 32'h20, 4'b1000, 1'b0);
    @(negedge clk);
    evt_in[37] = 1'b1;
    bus_wr = 1'b1; bus_addr = 9'h044; bus_wdata = 32'h20;
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R4 edge wins", 9'h004, 32'h20, 4'b1000, 1'b0);

    // R6: combined line holds while unmasked flag remains
    wr(9'h084, 32'hFFFF_FFDF);
    chk("R6 unmask", 9'h0A4, 32'h20, 4'b1010, 1'b0);
    repeat (10) @(negedge clk);
    chk("R6 hold", 9'h0A4, 32'h20, 4'b1010, 1'b0);
    evt_in[37] = 1'b0;
    wr(9'h044, 32'h20);
    chk("R6 drop", 9'h0A4, 32'h0, 4'b1000, 1'b0);

    // R1: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 flags", 9'h00C, 32'h0, 4'b0000, 1'b0);
    chk("R1 emask", 9'h08C, 32'hFFFF_FFFF, 4'b0000, 1'b0);
    chk("R1 xmask", 9'h0C8, 32'hFFFF_FFFF, 4'b0000, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule